// File: doc/BRIEF.md
# Multi-Format Stereo Serial Audio Receiver

This block turns a three-wire serial audio stream into parallel stereo samples. The three wires are a bit clock, a word-select clock and a data line. The block runs on a fast system clock and treats the bit clock and word clock as inputs already synchronized to that clock. It finds the rising edges of the bit clock and samples the data line on each one.

A 3-bit format code selects one of three framings: I2S, left-justified or right-justified. It also selects the sample length: 16, 20 or 24 bits. One shift register serves all framings. A small counter decides which bits of each slot are kept.

Each word-clock transition ends one channel slot. When a right-channel slot ends and its left partner is already held, the block presents both words together with a one-cycle strobe. Samples are two's complement and arrive most significant bit first. Each sample is output MSB-aligned in a 24-bit word, with unused low bits cleared to zero.

Top module: `stereo_serial_rx`

## Requirements
- R1: The data line is sampled only on rising edges of `bitClk`. Changes on `serData` while `bitClk` stays high have no effect.
- R2: In I2S framing the left slot is the `wordClk`-low phase. The MSB is the bit sampled on the second rising edge after the transition. Bits beyond the sample length are ignored.
- R3: In left-justified framing the left slot is the `wordClk`-high phase. The MSB is the bit sampled on the first rising edge at which the new `wordClk` level is seen. Bits beyond the sample length are ignored.
- R4: In right-justified framing the left slot is the `wordClk`-high phase. Only the last N bits before the next transition are kept, and earlier bits of the slot are ignored.
- R5: Format codes on `fmtSel`:
  - 000: 16-bit right-justified
  - 001: 20-bit right-justified
  - 010: 24-bit right-justified
  - 011: 24-bit left-justified
  - 100: 16-bit I2S
  - 101: 24-bit I2S

  An N-bit sample appears in bits [23:24-N] of the output, and the lower 24-N bits are zero.
- R6: Codes 110 and 111 behave exactly as 24-bit I2S. The format in effect after reset is 24-bit I2S.
- R7: Slot lengths that differ from half the frame by up to two bit clocks are received correctly, in every framing.
- R8: `pairValid` is high for exactly one cycle after each completed right slot whose left slot was received. A slot that was already running when reset was released produces no output. Each `pairValid` cycle corresponds to exactly one transmitted pair.
- R9: During reset, `pairValid` is low and both sample outputs are zero. The format code is taken at each word-clock transition and governs the slot that starts there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitClk | input | 1 | Serial bit clock, synchronous to clk |
| wordClk | input | 1 | Word-select clock marking left and right slots |
| serData | input | 1 | Serial sample data, MSB first |
| fmtSel | input | 3 | Framing and sample-length code |
| leftOut | output | 24 | Left sample, MSB-aligned |
| rightOut | output | 24 | Right sample, MSB-aligned |
| pairValid | output | 1 | One-cycle strobe marking a fresh stereo pair |

## Verification
The bench sends every format code, including both reserved ones, with left and right slots of 30, 32 and 34 bits. Trailing or leading filler bits are set to one, so a design that kept the wrong window of a slot would show corrupted low or high bits. Each run starts with a partial dummy slot, so a design that emitted a pair before receiving a full left word would leave an unexpected pair in the scoreboard. The data line is flipped while the bit clock is high, so a receiver that sampled on the wrong edge would return inverted bits. Extreme samples (most negative and most positive) expose a design that misaligns or drops the MSB for the shorter lengths.

// File: rtl/stereo_rx_pkg.sv
package stereo_rx_pkg;

  localparam int SAMPLE_W = 24;
  localparam int SHIFT_W  = 5;

  typedef enum logic [1:0] {
    MODE_RJ  = 2'd0,
    MODE_LJ  = 2'd1,
    MODE_I2S = 2'd2
  } modeE;

  typedef enum logic [1:0] {
    LEN16 = 2'd0,
    LEN20 = 2'd1,
    LEN24 = 2'd2
  } lenE;

  typedef struct packed {
    modeE mode;
    lenE  len;
  } fmtT;

  // strobes from control to datapath, meaningful on bit-clock rise cycles
  typedef struct packed {
    logic               shift;
    logic               restart;
    logic               restartKeep;
    logic               capture;
    logic               toLeft;
    logic               emit;
    logic [SHIFT_W-1:0] alignSh;
  } strobeT;

  function automatic fmtT decodeFmt(input logic [2:0] code);
    fmtT f;
    case (code)
      3'b000:  f = '{MODE_RJ,  LEN16};
      3'b001:  f = '{MODE_RJ,  LEN20};
      3'b010:  f = '{MODE_RJ,  LEN24};
      3'b011:  f = '{MODE_LJ,  LEN24};
      3'b100:  f = '{MODE_I2S, LEN16};
      default: f = '{MODE_I2S, LEN24};
    endcase
    return f;
  endfunction

  function automatic logic [SHIFT_W-1:0] lenBits(input lenE l);
    logic [SHIFT_W-1:0] n;
    case (l)
      LEN16:   n = SHIFT_W'(16);
      LEN20:   n = SHIFT_W'(20);
      default: n = SHIFT_W'(24);
    endcase
    return n;
  endfunction

endpackage

// File: rtl/stereo_rx_ctrl.sv
module stereo_rx_ctrl
  import stereo_rx_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitClk,
  input  logic       wordClk,
  input  logic [2:0] fmtSel,
  output strobeT     st,
  output modeE       curMode,
  output lenE        curLen
);

  logic             bckPrev;
  logic             lrckLast;
  logic             primed;
  logic             haveLeft;
  logic [CNT_W-1:0] bitCnt;
  fmtT              fmtCur;
  fmtT              fmtNew;
  fmtT              fmtAct;
  logic             rise;
  logic             boundary;
  logic             toLeft;
  logic             captureNow;

  always_comb begin
    rise       = bitClk & ~bckPrev;
    boundary   = rise & (wordClk != lrckLast);
    fmtNew     = decodeFmt(fmtSel);
    fmtAct     = boundary ? fmtNew : fmtCur;
    toLeft     = (fmtCur.mode == MODE_I2S) ? ~lrckLast : lrckLast;
    captureNow = boundary & primed;

    st             = '0;
    st.capture     = captureNow;
    st.toLeft      = toLeft;
    st.emit        = captureNow & ~toLeft & haveLeft;
    st.alignSh     = SHIFT_W'(SAMPLE_W) - lenBits(fmtCur.len);
    if (rise) begin
      if (boundary && fmtAct.mode != MODE_RJ) begin
        st.restart     = 1'b1;
        st.restartKeep = (fmtAct.mode == MODE_LJ);
      end else if (fmtAct.mode == MODE_RJ ||
                   bitCnt < CNT_W'(lenBits(fmtAct.len))) begin
        st.shift = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bckPrev  <= 1'b0;
      lrckLast <= 1'b0;
      primed   <= 1'b0;
      haveLeft <= 1'b0;
      bitCnt   <= '0;
      fmtCur   <= '{MODE_I2S, LEN24};
    end else begin
      bckPrev <= bitClk;
      if (rise) begin
        lrckLast <= wordClk;
        if (boundary) begin
          bitCnt <= (fmtAct.mode == MODE_LJ) ? CNT_W'(1) : '0;
        end else if (bitCnt != '1) begin
          bitCnt <= bitCnt + CNT_W'(1);
        end
      end
      if (boundary) begin
        primed <= 1'b1;
        fmtCur <= fmtNew;
      end
      if (captureNow) haveLeft <= toLeft;
    end
  end

  assign curMode = fmtCur.mode;
  assign curLen  = fmtCur.len;

endmodule

// File: rtl/stereo_rx_dp.sv
module stereo_rx_dp
  import stereo_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                serData,
  input  strobeT              st,
  output logic [SAMPLE_W-1:0] leftOut,
  output logic [SAMPLE_W-1:0] rightOut,
  output logic                pairValid
);

  logic [SAMPLE_W-1:0] shiftReg;
  logic [SAMPLE_W-1:0] leftHold;
  logic [SAMPLE_W-1:0] slotWord;

  assign slotWord = shiftReg << st.alignSh;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg  <= '0;
      leftHold  <= '0;
      leftOut   <= '0;
      rightOut  <= '0;
      pairValid <= 1'b0;
    end else begin
      pairValid <= st.emit;
      if (st.capture && st.toLeft) leftHold <= slotWord;
      if (st.emit) begin
        leftOut  <= leftHold;
        rightOut <= slotWord;
      end
      if (st.restart) begin
        shiftReg <= st.restartKeep ? {{(SAMPLE_W-1){1'b0}}, serData} : '0;
      end else if (st.shift) begin
        shiftReg <= {shiftReg[SAMPLE_W-2:0], serData};
      end
    end
  end

endmodule

// File: rtl/stereo_serial_rx.sv
module stereo_serial_rx
  import stereo_rx_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bitClk,
  input  logic                wordClk,
  input  logic                serData,
  input  logic [2:0]          fmtSel,
  output logic [SAMPLE_W-1:0] leftOut,
  output logic [SAMPLE_W-1:0] rightOut,
  output logic                pairValid
);

  strobeT st;
  modeE   curMode;
  lenE    curLen;

  stereo_rx_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .bitClk  (bitClk),
    .wordClk (wordClk),
    .fmtSel  (fmtSel),
    .st      (st),
    .curMode (curMode),
    .curLen  (curLen)
  );

  stereo_rx_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .serData   (serData),
    .st        (st),
    .leftOut   (leftOut),
    .rightOut  (rightOut),
    .pairValid (pairValid)
  );

endmodule

// File: rtl/stereo_rx_chk.sv
module stereo_rx_chk
  import stereo_rx_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                bitClk,
  input logic                wordClk,
  input logic                pairValid,
  input logic [SAMPLE_W-1:0] leftOut,
  input logic [SAMPLE_W-1:0] rightOut,
  input modeE                curMode,
  input lenE                 curLen
);

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    pairValid |=> !pairValid);                                           // R8

  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !pairValid |-> ($stable(leftOut) && $stable(rightOut)));             // R8

  AST_VALID_AFTER_BCK_RISE: assert property (@(posedge clk) disable iff (!rstN)
    pairValid |-> ($past(bitClk) && !$past(bitClk, 2)));                 // R1

  AST_PAIR_AT_LEFT_START: assert property (@(posedge clk) disable iff (!rstN)
    pairValid |-> ($past(wordClk) == ($past(curMode) != MODE_I2S)));     // R2

  AST_LOW_BITS_16: assert property (@(posedge clk) disable iff (!rstN)
    (pairValid && $past(curLen) == LEN16) |-> (rightOut[7:0] == 8'h00)); // R5

  AST_LOW_BITS_20: assert property (@(posedge clk) disable iff (!rstN)
    (pairValid && $past(curLen) == LEN20) |-> (rightOut[3:0] == 4'h0));  // R5

endmodule

bind stereo_serial_rx stereo_rx_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .bitClk    (bitClk),
  .wordClk   (wordClk),
  .pairValid (pairValid),
  .leftOut   (leftOut),
  .rightOut  (rightOut),
  .curMode   (curMode),
  .curLen    (curLen)
);

// File: tb/sim_stereo_serial_rx.sv
module sim_stereo_serial_rx;

  localparam int MD_RJ  = 0;
  localparam int MD_LJ  = 1;
  localparam int MD_I2S = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitClk = 1'b0;
  logic        wordClk = 1'b0;
  logic        serData = 1'b0;
  logic [2:0]  fmtSel = 3'b101;
  logic [23:0] leftOut;
  logic [23:0] rightOut;
  logic        pairValid;

  int          checks = 0;
  int          errors = 0;
  string       curReq = "R9";
  logic [47:0] expQ[$];
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  stereo_serial_rx u0 (
    .clk       (clk),
    .rstN      (rstN),
    .bitClk    (bitClk),
    .wordClk   (wordClk),
    .serData   (serData),
    .fmtSel    (fmtSel),
    .leftOut   (leftOut),
    .rightOut  (rightOut),
    .pairValid (pairValid)
  );

  // monitor: pop and compare each emitted pair
  always @(negedge clk) begin
    if (rstN && pairValid) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R8 unexpected pair: got %h/%h expected none", leftOut, rightOut);
      end else begin
        logic [47:0] e;
        e = expQ.pop_front();
        if ({leftOut, rightOut} !== e) begin
          errors++;
          $display("FAIL %s pair: got %h/%h expected %h/%h",
                   curReq, leftOut, rightOut, e[47:24], e[23:0]);
        end
      end
    end
  end

  task automatic sendBit(input logic lr, input logic d);
    @(negedge clk);
    bitClk  = 1'b0;
    wordClk = lr;
    serData = d;
    repeat (4) @(negedge clk);
    bitClk = 1'b1;
    repeat (2) @(negedge clk);
    serData = ~d; // R1: must not be taken while bitClk stays high
    repeat (2) @(negedge clk);
  endtask

  function automatic logic slotBit(input int md, input int n, input logic [23:0] v,
                                   input int i, input int s);
    if (md == MD_I2S) return (i >= 1 && i <= n) ? v[n-i] : 1'b1;
    if (md == MD_LJ)  return (i < n) ? v[n-1-i] : 1'b1;
    return (i >= s - n) ? v[s-1-i] : 1'b1;
  endfunction

  task automatic sendSlot(input int md, input int n, input logic lr,
                          input logic [23:0] v, input int s);
    for (int i = 0; i < s; i++) sendBit(lr, slotBit(md, n, v, i, s));
  endtask

  task automatic doReset(input logic [2:0] code);
    rstN    = 1'b0;
    bitClk  = 1'b0;
    wordClk = 1'b0;
    serData = 1'b0;
    fmtSel  = code;
    repeat (3) @(negedge clk);
    checks++;
    if (pairValid !== 1'b0 || leftOut !== 24'h0 || rightOut !== 24'h0) begin
      errors++;
      $display("FAIL R9 reset state: got %b/%h/%h expected 0/000000/000000",
               pairValid, leftOut, rightOut);
    end
    rstN = 1'b1;
  endtask

  // driver: sends pairs and pushes expected results into the scoreboard
  task automatic runFormat(input logic [2:0] code, input int md, input int n,
                           input string req);
    logic leftLvl;
    curReq  = req;
    leftLvl = (md == MD_I2S) ? 1'b0 : 1'b1;
    doReset(code);
    sendSlot(md, n, ~leftLvl, 24'h0, 8); // partial slot, must produce nothing (R8)
    for (int k = 0; k < 6; k++) begin
      logic [23:0] lv, rv, msk;
      int sl, sr;
      msk = (24'h1 << n) - 24'h1;
      case (k)
        0:       begin lv = 24'h1 << (n - 1); rv = msk >> 1; end
        1:       begin lv = msk >> 1; rv = 24'h1 << (n - 1); end
        2:       begin lv = msk; rv = 24'h0; end
        default: begin lv = 24'($urandom()) & msk; rv = 24'($urandom()) & msk; end
      endcase
      sl = 30 + 2 * (k % 3);      // R7: 30, 32, 34
      sr = 34 - 2 * (k % 3);
      sendSlot(md, n, leftLvl, lv, sl);
      sendSlot(md, n, ~leftLvl, rv, sr);
      expQ.push_back({lv << (24 - n), rv << (24 - n)});
    end
    sendBit(leftLvl, 1'b0);
    repeat (4) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R8 missing pairs for code %b: got %0d pending expected 0",
               code, expQ.size());
      expQ.delete();
    end
  endtask

  initial begin
    runFormat(3'b101, MD_I2S, 24, "R2 R7 R1");
    runFormat(3'b100, MD_I2S, 16, "R2 R5");
    runFormat(3'b011, MD_LJ,  24, "R3 R7");
    runFormat(3'b000, MD_RJ,  16, "R4 R5");
    runFormat(3'b001, MD_RJ,  20, "R4 R5");
    runFormat(3'b010, MD_RJ,  24, "R4 R7");
    runFormat(3'b110, MD_I2S, 24, "R6");
    runFormat(3'b111, MD_I2S, 24, "R6");
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule